// File: doc/BRIEF.md
# Stereo Bridge Gate Driver with Half-Cycle Dead Time

This block takes one switching command per half-bridge and turns it into the gate signals for the MOSFETs of a stereo bridge-tied-load output stage. Each of the two channels drives two half-bridges. Each half-bridge has a high-side P device and a low-side N device, so every half-bridge has one N-gate output and one P-gate output. A command bit of 1 asks for the P device of that half-bridge to conduct. A command bit of 0 asks for the N device to conduct.

A two-bit mode input chooses how the two devices of a half-bridge change over:
- In direct mode, both gates change on the same rising clock edge.
- In dead-time mode, the outgoing device is released on the rising edge and the incoming device is enabled on the following falling edge. This gives a break-before-make gap of exactly half a clock period, made without a counter.
- The remaining mode codes switch every device off.

An active-low mute input also switches every device off. While mute is low, commands have no effect.

Top module: `bdrv_bridge`

## Requirements
- R1: While `rst` is high at a rising edge, every N-gate output is driven to 0 and every P-gate output to 1 (all devices off) from that edge on.
- R2: Command and gate bit i belong to half-bridge i, where i = channel*LEGS + leg. Bit 0 is the left first pair, bit 1 the left second pair, bit 2 the right first pair and bit 3 the right second pair. A command bit of 1 selects the P device and 0 selects the N device.
- R3: An N-gate output is 1 when its device is on. A P-gate output is 0 when its device is on.
- R4: With `mode_sel` = 2'b00 and `mute_n` high, the command present at a rising edge sets both gates of each half-bridge at that same edge.
- R5: With `mode_sel` = 2'b01, a device whose command is withdrawn turns off at the rising edge that captures the new command.
- R6: With `mode_sel` = 2'b01, a newly commanded device turns on at the falling edge that follows the capturing rising edge, half a period after the other device turned off. A device that stays commanded stays on.
- R7: The N and P devices of a half-bridge are never on at the same time, in any mode.
- R8: When `mute_n` is low at a rising edge, all devices are off from that edge on, whatever the command.
- R9: After mute is released in dead-time mode, the commanded device turns on only at the falling edge that follows the first capturing rising edge.
- R10: A `mode_sel` value with bit 1 set is reserved and switches all devices off.
- R11: Each half-bridge follows only its own command bit. The two channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 direct, 01 dead time, 1x reserved (off) |
| mute_n | input | 1 | Active-low mute |
| cmd | input | N_CH*LEGS | Per-half-bridge command, 1 = P device on |
| gate_n | output | N_CH*LEGS | N-gate drive, high = on |
| gate_p | output | N_CH*LEGS | P-gate drive, low = on |

## Verification
The command patterns are chosen to separate different kinds of fault:
- Alternating and complementary patterns flip every half-bridge at once, and separate the direct-mode same-edge changeover from the dead-time split between the rising and falling edges.
- Patterns where only one channel changes, or where a command repeats, show whether channels leak into each other, and whether a device that stays commanded is wrongly dropped during the gap.
- Mute, the reserved codes and a mid-run reset are applied with all-ones and mixed commands, to show that the commands are ignored.
- A release from mute into dead-time mode shows that the output restarts from the off state.

Every output is sampled both just after the rising edge and just after the falling edge, so a turn-on that lands on the wrong edge is caught.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_DEAD   = 2'b01,
    MODE_RSV_A  = 2'b10,
    MODE_RSV_B  = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/bdrv_mode_dec.sv
module bdrv_mode_dec
  import bdrv_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       mute_n,
  output logic       drive_en,
  output logic       dead_en
);
  drv_mode_e mode;

  always_comb begin
    mode     = drv_mode_e'(mode_sel);
    drive_en = 1'b0;
    dead_en  = 1'b0;
    unique case (mode)
      MODE_DIRECT: drive_en = mute_n;
      MODE_DEAD: begin
        drive_en = mute_n;
        dead_en  = 1'b1;
      end
      default: drive_en = 1'b0;  // reserved codes: everything off
    endcase
  end
endmodule

// File: rtl/bdrv_leg.sv
module bdrv_leg (
  input  logic clk,
  input  logic rst,
  input  logic drive_en,
  input  logic dead_en,
  input  logic cmd,
  output logic gate_n,
  output logic gate_p
);
  logic want_hi, want_lo, dead_q;
  logic arm_hi, arm_lo;
  logic on_hi, on_lo;

  // Rising edge: capture the request; a withdrawn device drops here.
  always_ff @(posedge clk) begin
    if (rst) begin
      want_hi <= 1'b0;
      want_lo <= 1'b0;
      dead_q  <= 1'b0;
    end else begin
      want_hi <= drive_en & cmd;
      want_lo <= drive_en & ~cmd;
      dead_q  <= dead_en;
    end
  end

  // Falling edge: a copy of the request, half a period late, arms turn-on.
  always_ff @(negedge clk) begin
    if (rst) begin
      arm_hi <= 1'b0;
      arm_lo <= 1'b0;
    end else begin
      arm_hi <= want_hi;
      arm_lo <= want_lo;
    end
  end

  always_comb begin
    on_hi  = want_hi & (~dead_q | arm_hi);
    on_lo  = want_lo & (~dead_q | arm_lo);
    gate_n = on_lo;
    gate_p = ~on_hi;
  end
endmodule

// File: rtl/bdrv_channel.sv
module bdrv_channel #(
  parameter int LEGS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            drive_en,
  input  logic            dead_en,
  input  logic [LEGS-1:0] cmd,
  output logic [LEGS-1:0] gate_n,
  output logic [LEGS-1:0] gate_p
);
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    bdrv_leg u_leg (
      .clk      (clk),
      .rst      (rst),
      .drive_en (drive_en),
      .dead_en  (dead_en),
      .cmd      (cmd[g]),
      .gate_n   (gate_n[g]),
      .gate_p   (gate_p[g])
    );
  end
endmodule

// File: rtl/bdrv_bridge.sv
module bdrv_bridge #(
  parameter int N_CH = 2,
  parameter int LEGS = 2,
  localparam int W = N_CH * LEGS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_sel,
  input  logic         mute_n,
  input  logic [W-1:0] cmd,
  output logic [W-1:0] gate_n,
  output logic [W-1:0] gate_p
);
  logic drive_en, dead_en;

  bdrv_mode_dec u_dec (
    .mode_sel (mode_sel),
    .mute_n   (mute_n),
    .drive_en (drive_en),
    .dead_en  (dead_en)
  );

  // R11: one independent channel per slice of the command vector.
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    bdrv_channel #(.LEGS(LEGS)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .drive_en (drive_en),
      .dead_en  (dead_en),
      .cmd      (cmd[c*LEGS +: LEGS]),
      .gate_n   (gate_n[c*LEGS +: LEGS]),
      .gate_p   (gate_p[c*LEGS +: LEGS])
    );
  end
endmodule

// File: rtl/bdrv_bridge_chk.sv
module bdrv_bridge_chk #(
  parameter int N_CH = 2,
  parameter int LEGS = 2,
  localparam int W = N_CH * LEGS
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_sel,
  input logic         mute_n,
  input logic [W-1:0] cmd,
  input logic [W-1:0] gate_n,
  input logic [W-1:0] gate_p
);
  logic [2*W-1:0] on_rise_q;
  logic           dead_rise_q;
  logic           chk_valid;

  // Device-on set as it stood just before each rising edge.
  always_ff @(posedge clk) begin
    on_rise_q   <= {gate_n, ~gate_p};
    dead_rise_q <= (mode_sel == 2'b01);
    chk_valid   <= ~rst;
  end

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    ((gate_n & ~gate_p) == '0));

  p_no_overlap_fall_r7: assert property (@(negedge clk) disable iff (rst)
    ((gate_n & ~gate_p) == '0));

  p_direct_same_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00 && mute_n) |=>
      (gate_n == ~$past(cmd) && gate_p == ~$past(cmd)));

  p_dead_settles_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && mute_n) |=>
      (gate_n == ~$past(cmd) && gate_p == ~$past(cmd)));

  // R5/R6: between a rising edge and the next falling edge nothing turns on.
  p_dead_no_early_on_r5: assert property (@(negedge clk) disable iff (rst)
    (chk_valid && dead_rise_q) |->
      (({gate_n, ~gate_p} & ~on_rise_q) == '0));

  p_mute_off_r8: assert property (@(posedge clk) disable iff (rst)
    !mute_n |=> (gate_n == '0 && gate_p == '1));

  p_reserved_off_r10: assert property (@(posedge clk) disable iff (rst)
    mode_sel[1] |=> (gate_n == '0 && gate_p == '1));
endmodule

bind bdrv_bridge bdrv_bridge_chk #(.N_CH(N_CH), .LEGS(LEGS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .mute_n   (mute_n),
  .cmd      (cmd),
  .gate_n   (gate_n),
  .gate_p   (gate_p)
);

// File: tb/sim_bdrv_bridge.sv
module sim_bdrv_bridge;
  localparam int CLK_P = 10;
  localparam int W = 4;
  localparam int NV = 17;

  // Each row: {mode_sel[1:0], mute_n, cmd[3:0]}
  localparam logic [6:0] VEC [NV] = '{
    7'b00_1_0000, 7'b00_1_1010, 7'b00_1_0101, 7'b01_1_0101,
    7'b01_1_1010, 7'b01_1_1100, 7'b01_1_0011, 7'b01_0_1111,
    7'b01_0_0000, 7'b01_1_1111, 7'b00_1_0000, 7'b10_1_1111,
    7'b11_1_0110, 7'b00_1_0110, 7'b01_1_0110, 7'b00_0_1001,
    7'b01_1_1001
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'b00;
  logic         mute_n = 1'b0;
  logic [W-1:0] cmd = '0;
  logic [W-1:0] gate_n, gate_p;

  int total = 0;
  int bad = 0;
  logic [W-1:0] prev_n = '0, prev_p = '0;

  always #(CLK_P/2) clk = ~clk;

  bdrv_bridge u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .mute_n(mute_n),
    .cmd(cmd), .gate_n(gate_n), .gate_p(gate_p)
  );

  task automatic check(input string tag, input logic [2*W-1:0] got,
                       input logic [2*W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // R7: never both devices of a pair on.
  task automatic check_overlap();
    check("R7", {4'b0, gate_n & ~gate_p}, '0);
  endtask

  task automatic step(input logic [6:0] v);
    logic [W-1:0] rq_n, rq_p, e_n, e_p;
    logic en, dead;
    string tag;
    mode_sel = v[6:5];
    mute_n   = v[4];
    cmd      = v[3:0];
    en   = !v[6] && v[4];
    dead = (v[6:5] == 2'b01);
    // R2/R3: bit 1 = P device on (gate_p low), bit 0 = N device on (gate_n high)
    rq_p = en ? v[3:0] : '0;
    rq_n = en ? ~v[3:0] : '0;
    if (v[6]) tag = "R10";
    else if (!v[4]) tag = "R8";
    else if (dead) tag = "R5";
    else tag = "R4";
    e_p = dead ? (rq_p & prev_p) : rq_p;
    e_n = dead ? (rq_n & prev_n) : rq_n;
    @(posedge clk); #1;
    check(tag, {gate_n, gate_p}, {e_n, ~e_p});
    check_overlap();
    @(negedge clk); #1;
    if (dead && en) tag = "R6";
    check(tag, {gate_n, gate_p}, {rq_n, ~rq_p});
    check_overlap();
    prev_n = rq_n;
    prev_p = rq_p;
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {gate_n, gate_p}, {4'b0000, 4'b1111});
    @(negedge clk); #1;
    rst = 1'b0;
    // Table walk covers R2, R3, R9 (row 10: mute release in dead mode) and R11
    for (int i = 0; i < NV; i++) step(VEC[i]);
    // R11: change only the right channel, left pairs keep their state
    step(7'b00_1_1001);
    step(7'b00_1_0101);
    // R1: reset in the middle of dead-mode drive forces all off
    step(7'b01_1_1111);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", {gate_n, gate_p}, {4'b0000, 4'b1111});
    @(negedge clk); #1;
    check("R1", {gate_n, gate_p}, {4'b0000, 4'b1111});
    rst = 1'b0;
    prev_n = '0;
    prev_p = '0;
    // R9: restart after reset in dead mode begins from off
    step(7'b01_1_0110);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule